// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block steps an 8-bit processor's bus interface through the T-states of one machine cycle. The address is 16 bits wide. Its upper byte has dedicated output lines. Its lower byte shares a set of pins with the data. A client asks for an opcode fetch, a memory read or a memory write by raising a request with an address and, for writes, a data byte.

The sequencer then drives the following:
- the address-latch strobe in the first T-state, so that external logic can hold the low address byte;
- the active-low read and write strobes;
- the three status outputs that mark the cycle type;
- the direction of the shared pins.

Read and fetch data is captured at the close of the third T-state. An opcode fetch adds a decode state. A decode result sampled in that state can stretch the fetch to five or six T-states.

A one-cycle completion pulse marks the final T-state. A new request presented in that same state starts the next cycle without an idle gap.

Top module: `bus_cycle_seq`

## Requirements
- R1: In T1 `ale` is 1, `ad_oe` is 1, `ad_out` carries address bits [7:0] and `a_hi` carries address bits [15:8]. `ale` is 0 in every other state.
- R2: `a_hi` keeps the request's upper address byte for the whole cycle. The low address byte appears on `ad_out` only in T1.
- R3: Status `{io_m,s1,s0}` is 3'b011 for a fetch (`req_kind`=0), 3'b010 for a read (`req_kind`=1) and 3'b001 for a write (`req_kind`=2). It holds from T1 to the last T-state and is 3'b000 when idle.
- R4: In a read or fetch, `rd_n` is 0 in T2 and T3 and 1 elsewhere, and `ad_oe` is 0 in T2 and T3. The value on `ad_in` at the end of T3 appears on `rdata` and is kept until the next read or fetch.
- R5: In a write, `wr_n` is 0 in T2 and T3, `ad_oe` is 1, and `ad_out` carries the write byte. `rd_n` stays 1 and `rdata` is unchanged.
- R6: Reads and writes last three T-states. A fetch lasts 4 + n T-states. Here n is `dec_extra` sampled in T4, where 0 gives 4, 1 gives 5, and 2 or 3 give 6. `dec_extra` has no effect outside T4.
- R7: `done` is 1 for exactly the final T-state of a cycle. `ready` is 1 when idle or in that final state, and `busy` is 1 from T1 to the final state.
- R8: A request accepted in the final T-state starts T1 of the next cycle on the following clock.
- R9: A request with `req_kind`=3 is ignored: the block stays idle with all strobes inactive.
- R10: During and right after reset, the block is idle with the following values:
  - `ale`=0
  - `rd_n`=1 and `wr_n`=1
  - `ad_oe`=0
  - `a_hi`=0
  - status 3'b000
  - `rdata`=0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Cycle request, taken when `ready` is 1 |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 reserved |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| dec_extra | input | 2 | Extra fetch T-states, sampled in T4 |
| ad_in | input | 8 | Shared-pin input value |
| ad_out | output | 8 | Shared-pin output value |
| ad_oe | output | 1 | Shared-pin output enable |
| a_hi | output | 8 | Upper address byte lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | Status: I/O versus memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rdata | output | 8 | Captured read/fetch byte |
| busy | output | 1 | A cycle is in progress |
| ready | output | 1 | A request can be taken this cycle |
| done | output | 1 | Final T-state of a cycle |

## Verification
The bench sweeps every cycle kind against every decode value and several address and data patterns. It checks every pin in every T-state.

The corner cases it targets are these:
- Read data is placed on `ad_in` only during T3, so a sequencer that captures one state early or late stores the inverted byte.
- `dec_extra` is flipped after T4, so a design that looks at it again in T5 stretches or shortens the fetch.
- A write is followed by a check that `rdata` kept its old value.
- A second request is issued in the final state, which catches a dead idle cycle between back-to-back cycles.
- A reserved request kind is issued to catch a design that starts a phantom cycle.

// File: rtl/bcs_pkg.sv
// Package bcs_pkg
// Shared types for the bus cycle sequencer: the T-state encoding and the
// request kinds. Assumes one T-state per clock.
package bcs_pkg;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_T4   = 3'd4,
        TS_T5   = 3'd5,
        TS_T6   = 3'd6
    } tstate_e;

    typedef enum logic [1:0] {
        CK_FETCH = 2'd0,
        CK_READ  = 2'd1,
        CK_WRITE = 2'd2,
        CK_RSVD  = 2'd3
    } cyc_kind_e;

    // Status triple {io_m, s1, s0} for each request kind
    function automatic logic [2:0] status_of(input cyc_kind_e k);
        case (k)
            CK_FETCH: return 3'b011;
            CK_READ:  return 3'b010;
            CK_WRITE: return 3'b001;
            default:  return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/bcs_tstate_fsm.sv
// Module bcs_tstate_fsm
// Advances the T-state register. It takes a request when idle or in the
// final T-state and flags that final state. Assumes kind_q holds the kind
// of the cycle in progress (latched on accept by bcs_req_latch).
module bcs_tstate_fsm
    import bcs_pkg::*;
#(
    parameter int EXT_W   = 2,
    parameter int EXT_MAX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  cyc_kind_e        req_kind,
    input  cyc_kind_e        kind_q,
    input  logic [EXT_W-1:0] dec_extra,
    output tstate_e          state,
    output logic             accept,
    output logic             ready,
    output logic             last,
    output logic             cap_en
);

    localparam logic [EXT_W-1:0] EXT_SAT = EXT_W'(EXT_MAX);

    logic [EXT_W-1:0] ext_q;
    logic [EXT_W-1:0] ext_sat;
    tstate_e          nxt;

    // Clamp the decode result to the longest supported fetch
    always_comb ext_sat = (dec_extra > EXT_SAT) ? EXT_SAT : dec_extra;

    // Decide whether this state closes the cycle
    always_comb begin
        case (state)
            TS_T3:   last = (kind_q != CK_FETCH);
            TS_T4:   last = (ext_sat == '0);
            TS_T5:   last = (ext_q < EXT_W'(2));
            TS_T6:   last = 1'b1;
            default: last = 1'b0;
        endcase
    end

    // Handshake: take a non-reserved request when idle or finishing
    always_comb begin
        ready  = (state == TS_IDLE) || last;
        accept = req_valid && ready && (req_kind != CK_RSVD);
        cap_en = (state == TS_T3) && (kind_q != CK_WRITE);
    end

    // Next-state selection
    always_comb begin
        if (last || state == TS_IDLE) begin
            nxt = accept ? TS_T1 : TS_IDLE;
        end else begin
            case (state)
                TS_T1:   nxt = TS_T2;
                TS_T2:   nxt = TS_T3;
                TS_T3:   nxt = TS_T4;
                TS_T4:   nxt = TS_T5;
                TS_T5:   nxt = TS_T6;
                default: nxt = TS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TS_IDLE;
        else        state <= nxt;
    end

    // Hold the decode result taken in T4 for the T5 decision
    always_ff @(posedge clk) begin
        if (!rst_n)               ext_q <= '0;
        else if (state == TS_T4)  ext_q <= ext_sat;
    end

endmodule

// File: rtl/bcs_req_latch.sv
// Module bcs_req_latch
// Holds the accepted request for the life of its cycle and captures the
// shared-pin input byte when told to. Assumes accept is only high in idle
// or in a final T-state.
module bcs_req_latch
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  cyc_kind_e         req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] ad_in,
    output cyc_kind_e         kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata
);

    // Latch the request fields on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= CK_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            kind_q  <= req_kind;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture read or fetch data at the close of T3
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (cap_en) rdata <= ad_in;
    end

endmodule

// File: rtl/bcs_pin_drive.sv
// Module bcs_pin_drive
// Decodes the T-state and latched request into bus pin values. Purely
// combinational. Assumes addr_q and kind_q are stable for the whole cycle.
module bcs_pin_drive
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  tstate_e                  state,
    input  cyc_kind_e                kind_q,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [2:0]               status
);

    logic active;
    logic strobe_win;
    logic is_wr;

    // Classify the current state
    always_comb begin
        active     = (state != TS_IDLE);
        strobe_win = (state == TS_T2) || (state == TS_T3);
        is_wr      = (kind_q == CK_WRITE);
    end

    // Address, status and latch strobe
    always_comb begin
        ale    = (state == TS_T1);
        a_hi   = active ? addr_q[ADDR_W-1:DATA_W] : '0;
        status = active ? status_of(kind_q) : 3'b000;
    end

    // Read and write strobes
    always_comb begin
        rd_n = !(strobe_win && !is_wr);
        wr_n = !(strobe_win && is_wr);
    end

    // Shared-pin direction and content
    always_comb begin
        if (state == TS_T1) begin
            ad_oe  = 1'b1;
            ad_out = addr_q[DATA_W-1:0];
        end else if (strobe_win && is_wr) begin
            ad_oe  = 1'b1;
            ad_out = wdata_q;
        end else begin
            ad_oe  = 1'b0;
            ad_out = '0;
        end
    end

endmodule

// File: rtl/bus_cycle_seq.sv
// Module bus_cycle_seq
// Top of the multiplexed address/data bus cycle sequencer. It wires the
// T-state machine, the request latch and the pin decoder. Assumes the
// external latch grabs the low address byte while ale is high.
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int EXT_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [EXT_W-1:0]         dec_extra,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic [DATA_W-1:0]        rdata,
    output logic                     busy,
    output logic                     ready,
    output logic                     done
);

    tstate_e           state;
    cyc_kind_e         kind_q;
    cyc_kind_e         kind_in;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;
    logic              last;
    logic              cap_en;
    logic [2:0]        status;

    // Cast the raw request kind
    always_comb kind_in = cyc_kind_e'(req_kind);

    bcs_tstate_fsm #(.EXT_W(EXT_W), .EXT_MAX(2)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (kind_in),
        .kind_q    (kind_q),
        .dec_extra (dec_extra),
        .state     (state),
        .accept    (accept),
        .ready     (ready),
        .last      (last),
        .cap_en    (cap_en)
    );

    bcs_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_kind  (kind_in),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cap_en    (cap_en),
        .ad_in     (ad_in),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata     (rdata)
    );

    bcs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .state   (state),
        .kind_q  (kind_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .a_hi    (a_hi),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .status  (status)
    );

    // Split status and report cycle progress
    always_comb begin
        {io_m, s1, s0} = status;
        busy           = (state != TS_IDLE);
        done           = last;
    end

endmodule

// File: rtl/bus_cycle_seq_chk.sv
// Module bus_cycle_seq_chk
// Port-level protocol checks for bus_cycle_seq, attached by bind.
module bus_cycle_seq_chk #(
    parameter int HI_W   = 8,
    parameter int DATA_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            ad_oe,
    input logic [HI_W-1:0] a_hi,
    input logic            busy,
    input logic            done,
    input logic            io_m,
    input logic            s1,
    input logic            s0
);

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R1
    AST_AHI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale) |-> $stable(a_hi)); // R2
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale) |-> $stable({io_m, s1, s0})); // R3
    AST_RD_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R4
    AST_RD_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(ale)); // R4
    AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && rd_n)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && !ale && !ad_oe)); // R10

endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(
    .HI_W   (ADDR_W - DATA_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ale   (ale),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .ad_oe (ad_oe),
    .a_hi  (a_hi),
    .busy  (busy),
    .done  (done),
    .io_m  (io_m),
    .s1    (s1),
    .s0    (s0)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [1:0] dec_extra = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out, a_hi, rdata;
    logic       ad_oe, ale, rd_n, wr_n, io_m, s1, s0, busy, ready, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] exp_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .dec_extra(dec_extra),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0), .rdata(rdata),
        .busy(busy), .ready(ready), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_status(input logic [1:0] k);
        return (k == 2'd0) ? 3'b011 : (k == 2'd1) ? 3'b010 : 3'b001;
    endfunction

    // One full cycle, checking every pin in every T-state
    task automatic run_cyc(input logic [1:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input logic [1:0] ext,
                           input logic [7:0] rv);
        int len;
        bit w;
        len = (k == 2'd0) ? 4 + ((ext > 2'd2) ? 2 : int'(ext)) : 3;
        w = (k == 2'd2);
        @(negedge clk);
        req_valid = 1; req_kind = k; req_addr = a; req_wdata = wd; dec_extra = ext;
        ad_in = ~rv;
        for (int t = 1; t <= len; t++) begin
            @(negedge clk);
            if (t == 1) begin req_valid = 0; req_addr = ~a; req_wdata = ~wd; end
            ad_in = (t == 3) ? rv : ~rv;
            if (t == 5) dec_extra = ~ext; // R6: no effect after T4
            chk("R1", "ale", ale, t == 1);
            chk("R2", "a_hi", a_hi, a[15:8]);
            chk("R3", "status", {io_m, s1, s0}, exp_status(k));
            chk("R4", "ad_oe", ad_oe, (t == 1) || (w && (t == 2 || t == 3)));
            if (t == 1) chk("R1", "ad_out addr", ad_out, a[7:0]);
            if (w && (t == 2 || t == 3)) chk("R5", "ad_out wdata", ad_out, wd);
            chk("R4", "rd_n", rd_n, !(!w && (t == 2 || t == 3)));
            chk("R5", "wr_n", wr_n, !(w && (t == 2 || t == 3)));
            chk("R6", "done at T-state", done, t == len);
            chk("R7", "busy", busy, 1);
            chk("R7", "ready", ready, t == len);
        end
        @(negedge clk);
        if (!w) exp_rdata = rv;
        chk("R6", "idle after length", busy, 0);
        chk("R7", "done low in idle", done, 0);
        chk(w ? "R5" : "R4", "rdata", rdata, exp_rdata);
        chk("R3", "idle status", {io_m, s1, s0}, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "busy in reset", busy, 0);
        chk("R10", "strobes in reset", {ale, rd_n, wr_n, ad_oe}, 4'b0110);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R10", "idle after reset", {busy, ale, rd_n, wr_n, ad_oe}, 5'b00110);
        chk("R10", "a_hi after reset", a_hi, 0);
        chk("R10", "status after reset", {io_m, s1, s0}, 3'b000);
        chk("R10", "rdata after reset", rdata, 0);

        // Sweep kinds, decode values and address/data patterns
        for (int k = 0; k < 3; k++)
            for (int e = 0; e < 4; e++)
                for (int p = 0; p < 3; p++) begin
                    logic [15:0] a;
                    logic [7:0] d;
                    a = 16'h1234 * (p + 1) + 16'(k * 97 + e * 13);
                    d = 8'(8'h5A + p * 37 + k * 11 + e);
                    run_cyc(2'(k), a, d, 2'(e), ~d);
                end

        // R9: reserved kind is ignored
        @(negedge clk); req_valid = 1; req_kind = 2'd3; req_addr = 16'hBEEF;
        @(negedge clk); req_valid = 0;
        chk("R9", "reserved busy", busy, 0);
        chk("R9", "reserved strobes", {ale, rd_n, wr_n, ad_oe}, 4'b0110);
        @(negedge clk);
        chk("R9", "reserved still idle", busy, 0);

        // R8: back-to-back read then write
        @(negedge clk); req_valid = 1; req_kind = 2'd1; req_addr = 16'hA55A;
        @(negedge clk); req_valid = 0;
        @(negedge clk); ad_in = 8'h3C;
        @(negedge clk);
        chk("R8", "done in read T3", done, 1);
        req_valid = 1; req_kind = 2'd2; req_addr = 16'h7E81; req_wdata = 8'hC3;
        @(negedge clk); req_valid = 0;
        chk("R8", "next T1 ale", ale, 1);
        chk("R8", "next status", {io_m, s1, s0}, 3'b001);
        chk("R8", "next a_hi", a_hi, 8'h7E);
        chk("R8", "next low byte", ad_out, 8'h81);
        chk("R4", "b2b rdata", rdata, 8'h3C);
        @(negedge clk);
        chk("R8", "write T2 wr_n", wr_n, 0);
        @(negedge clk);
        chk("R8", "write T3 done", done, 1);
        @(negedge clk);
        chk("R8", "idle after b2b", busy, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule